// File: doc/BRIEF.md
# Synthesizer Control Word Decoder

This block sits behind the serial load port of a fractional-N frequency synthesizer. A 32-bit word arrives together with a one-cycle `word_valid` strobe. The three lowest bits of the word are a control code that picks one of `NUM_SLOTS` internal slots. The remaining upper bits are stored in that slot on the same clock edge. Codes that have no slot are dropped.

Slot 3 is the function slot, and the synthesizer core's control lines are decoded from it. Those lines are counter hold, charge-pump high-impedance, software sleep, lock-detect clear, phase-detector polarity, lock-detect precision and modulator phase policy. A cycle-slip enable comes from bit 24 of slot 2 and is gated by the polarity. Slot 0 holds the main divider. A write to slot 0 produces a one-clock modulator restart pulse unless the policy bit asks to keep the phase.

A two-state machine tracks software sleep. `ST_RUN` moves to `ST_SLEEP` on transition GO_SLEEP, which is a function write with bit 5 set. `ST_SLEEP` returns to `ST_RUN` on transition WAKE, which is a function write with bit 5 clear. Any other cycle is transition STAY. While the machine is in `ST_SLEEP`, the counter hold, charge-pump high-impedance and lock-detect clear outputs are all forced high. The stored slots keep their contents and still take new words.

Top module: `synth_ctl_decoder`

## Requirements
- R1: After the asynchronous active-low reset, every slot reads zero and every output is 0.
- R2: A strobed word whose code (bits 2:0) is below `NUM_SLOTS` stores bits 31:3 into that slot, and the other slots stay unchanged. Codes 5, 6 and 7 change nothing.
- R3: `cnt_hold` is 1 when function bit 3 is 1 or the block is asleep, and 0 otherwise.
- R4: `cp_tristate` is 1 when function bit 4 is 1 or the block is asleep, and 0 otherwise.
- R5: Function bit 5 = 1 enters sleep, which raises `pwr_down` and `ld_clear`. Function bit 5 = 0 leaves sleep.
- R6: While asleep, strobed words are still stored, and slots that are not written keep their contents.
- R7: `pd_positive` follows function bit 6 (1 = positive) and `ld_precise` follows function bit 7 (1 = tighter threshold).
- R8: `mod_hold` follows function bit 14. With bit 14 = 0, each write to slot 0 makes `mod_restart` high for exactly the one cycle after the capturing edge. With bit 14 = 1, no pulse is made.
- R9: `slip_en` is slot 2 bit 24 AND `pd_positive`, so it is 0 whenever the polarity is negative.
- R10: Outputs change only at the edge that captures a strobed word. Without a strobe they hold, and `mod_restart` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | Strobe: capture `word_data` at this edge |
| word_data | input | 32 | Loaded word, control code in bits 2:0 |
| cnt_hold | output | 1 | Hold synthesizer counters in load state |
| cp_tristate | output | 1 | Charge pump high-impedance |
| pwr_down | output | 1 | Software sleep active |
| ld_clear | output | 1 | Clear lock-detect logic |
| pd_positive | output | 1 | Phase detector polarity, 1 = positive |
| ld_precise | output | 1 | Lock-detect tighter threshold select |
| mod_hold | output | 1 | Modulator keeps phase on divider writes |
| slip_en | output | 1 | Cycle-slip reduction enable |
| mod_restart | output | 1 | One-clock modulator restart pulse |
| regs_o | output | NUM_SLOTS*29 | Stored slots, slot i at bits [i*29 +: 29] |

## Verification
The sleep forcing and the modulator restart can be active in the same cycle. To provoke this, the bench enters sleep with policy bit 14 clear and then writes the divider slot. It then requires `mod_restart` high in the following cycle while `pwr_down`, `cnt_hold` and `cp_tristate` also stay high and the divider slot shows the new value. Back-to-back divider writes are also driven, and they must keep the pulse high for two cycles and then drop it.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
    localparam int CODE_W   = 3;
    localparam int CODE_DIV = 0;
    localparam int CODE_AUX = 2;
    localparam int CODE_FN  = 3;

    // word bit positions decoded by the core
    localparam int FN_CNT_HOLD = 3;
    localparam int FN_CP_HIZ   = 4;
    localparam int FN_SLEEP    = 5;
    localparam int FN_POLARITY = 6;
    localparam int FN_LD_PREC  = 7;
    localparam int FN_KEEP_PH  = 14;
    localparam int AUX_SLIP    = 24;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/synth_slot_bank.sv
module synth_slot_bank #(
    parameter int WORD_W    = 32,
    parameter int CODE_W    = 3,
    parameter int NUM_SLOTS = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WORD_W-1:0]             wr_word,
    output logic [NUM_SLOTS-1:0]          wr_hit,
    output logic [NUM_SLOTS*(WORD_W-CODE_W)-1:0] slots
);
    localparam int FIELD_W = WORD_W - CODE_W;

    logic [CODE_W-1:0]  code;
    logic [FIELD_W-1:0] field;

    assign code  = wr_word[CODE_W-1:0];
    assign field = wr_word[WORD_W-1:CODE_W];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign wr_hit[g] = wr_en && (code == CODE_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[g*FIELD_W +: FIELD_W] <= '0;
            end else if (wr_hit[g]) begin
                slots[g*FIELD_W +: FIELD_W] <= field;
            end
        end

        p_slot_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit[g] |=> $stable(slots[g*FIELD_W +: FIELD_W]));
    end

    p_hit_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));
endmodule

// File: rtl/synth_power_fsm.sv
module synth_power_fsm
    import synth_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fn_wr,
    input  logic fn_wr_sleep,
    input  logic fn_cnt_hold,
    input  logic fn_cp_hiz,
    output logic cnt_hold,
    output logic cp_tristate,
    output logic pwr_down,
    output logic ld_clear
);
    pwr_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (fn_wr && fn_wr_sleep)  state_nx = ST_SLEEP; // GO_SLEEP
            ST_SLEEP: if (fn_wr && !fn_wr_sleep) state_nx = ST_RUN;   // WAKE
            default:  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_SLEEP: begin
                cnt_hold    = 1'b1;
                cp_tristate = 1'b1;
                pwr_down    = 1'b1;
                ld_clear    = 1'b1;
            end
            default: begin
                cnt_hold    = fn_cnt_hold;
                cp_tristate = fn_cp_hiz;
                pwr_down    = 1'b0;
                ld_clear    = 1'b0;
            end
        endcase
    end

    p_sleep_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fn_wr |=> (pwr_down == $past(fn_wr_sleep)));
    p_sleep_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_wr |=> $stable(pwr_down));
endmodule

// File: rtl/synth_mod_restart.sv
module synth_mod_restart (
    input  logic clk,
    input  logic rst_n,
    input  logic div_wr,
    input  logic keep_phase,
    output logic mod_restart
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mod_restart <= 1'b0;
        else        mod_restart <= div_wr && !keep_phase;
    end

    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_restart) |-> $past(div_wr));
    p_pulse_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && keep_phase) |=> !mod_restart);
    p_pulse_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !div_wr |=> !mod_restart);
endmodule

// File: rtl/synth_ctl_decoder.sv
module synth_ctl_decoder
    import synth_ctl_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_SLOTS = 5,
    localparam int FIELD_W  = WORD_W - CODE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          word_valid,
    input  logic [WORD_W-1:0]             word_data,
    output logic                          cnt_hold,
    output logic                          cp_tristate,
    output logic                          pwr_down,
    output logic                          ld_clear,
    output logic                          pd_positive,
    output logic                          ld_precise,
    output logic                          mod_hold,
    output logic                          slip_en,
    output logic                          mod_restart,
    output logic [NUM_SLOTS*FIELD_W-1:0]  regs_o
);
    logic [NUM_SLOTS-1:0] wr_hit;
    logic [FIELD_W-1:0]   fn_field;
    logic [FIELD_W-1:0]   aux_field;

    synth_slot_bank #(
        .WORD_W   (WORD_W),
        .CODE_W   (CODE_W),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (word_valid),
        .wr_word(word_data),
        .wr_hit (wr_hit),
        .slots  (regs_o)
    );

    assign fn_field  = regs_o[CODE_FN*FIELD_W  +: FIELD_W];
    assign aux_field = regs_o[CODE_AUX*FIELD_W +: FIELD_W];

    synth_power_fsm u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fn_wr      (wr_hit[CODE_FN]),
        .fn_wr_sleep(word_data[FN_SLEEP]),
        .fn_cnt_hold(fn_field[FN_CNT_HOLD-CODE_W]),
        .fn_cp_hiz  (fn_field[FN_CP_HIZ-CODE_W]),
        .cnt_hold   (cnt_hold),
        .cp_tristate(cp_tristate),
        .pwr_down   (pwr_down),
        .ld_clear   (ld_clear)
    );

    assign pd_positive = fn_field[FN_POLARITY-CODE_W];
    assign ld_precise  = fn_field[FN_LD_PREC-CODE_W];
    assign mod_hold    = fn_field[FN_KEEP_PH-CODE_W];
    assign slip_en     = aux_field[AUX_SLIP-CODE_W] && pd_positive;

    synth_mod_restart u_restart (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_wr     (wr_hit[CODE_DIV]),
        .keep_phase (mod_hold),
        .mod_restart(mod_restart)
    );

    p_sleep_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fn_field[FN_SLEEP-CODE_W] |-> (pwr_down && cnt_hold && cp_tristate && ld_clear));
    p_retain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !word_valid) |=> $stable(regs_o));
    p_slip_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_positive |-> !slip_en);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable({cnt_hold, cp_tristate, pwr_down, pd_positive,
                                 ld_precise, mod_hold, slip_en}));
endmodule

// File: tb/synth_ctl_decoder_bench.sv
`timescale 1ns/1ps
module synth_ctl_decoder_bench;
    localparam int NS = 5;
    localparam int FW = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic cnt_hold, cp_tristate, pwr_down, ld_clear, pd_positive;
    logic ld_precise, mod_hold, slip_en, mod_restart;
    logic [NS*FW-1:0] regs_o;
    logic [7:0] obs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    synth_ctl_decoder u_synth_ctl_decoder (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .cnt_hold(cnt_hold), .cp_tristate(cp_tristate), .pwr_down(pwr_down),
        .ld_clear(ld_clear), .pd_positive(pd_positive), .ld_precise(ld_precise),
        .mod_hold(mod_hold), .slip_en(slip_en), .mod_restart(mod_restart),
        .regs_o(regs_o)
    );

    // {slip_en, mod_hold, ld_precise, pd_positive, ld_clear, pwr_down, cp_tristate, cnt_hold}
    assign obs = {slip_en, mod_hold, ld_precise, pd_positive,
                  ld_clear, pwr_down, cp_tristate, cnt_hold};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] w);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = '0;
    endtask

    function automatic logic [31:0] slot(input int i);
        return {3'b000, regs_o[i*FW +: FW]};
    endfunction

    // {word, expected obs}
    localparam logic [39:0] VEC [12] = '{
        {32'h0000_000B, 8'b0000_0001},  // R3 counter hold
        {32'h0000_0013, 8'b0000_0010},  // R4 charge pump hi-z
        {32'h0000_0043, 8'b0001_0000},  // R7 polarity
        {32'h0000_0083, 8'b0010_0000},  // R7 precision
        {32'h0000_4003, 8'b0100_0000},  // R8 keep-phase policy
        {32'h0100_0002, 8'b0100_0000},  // R9 slip requested, polarity negative
        {32'h0000_0043, 8'b1001_0000},  // R9 slip passes with positive
        {32'h0000_0023, 8'b0000_1111},  // R5 sleep forces
        {32'h0000_0063, 8'b1001_1111},  // R5 sleep plus polarity
        {32'h0000_0005, 8'b1001_1111},  // R2 code 5 ignored
        {32'h0000_0143, 8'b1001_0000},  // R5 wake
        {32'h0000_0000, 8'b1001_0000}   // R2 divider write, function unchanged
    };

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #7;
        chk("R1 outputs in reset", {23'd0, mod_restart, obs}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {23'd0, mod_restart, obs}, 32'd0);
        for (int i = 0; i < NS; i++) chk("R1 slot zero", slot(i), 32'd0);

        for (int v = 0; v < 12; v++) begin
            load(VEC[v][39:8]);
            chk($sformatf("R2-R9 vector %0d", v), {24'd0, obs}, {24'd0, VEC[v][7:0]});
        end
        chk("R2 slot2 content", slot(2), 32'h0020_0000);
        chk("R2 slot3 content", slot(3), 32'h0000_0028);

        // R8: policy bit 14 = 1 at this point? function is 0x143 -> bit14 = 0
        load(32'h0000_1230);
        chk("R8 pulse after divider write", {31'd0, mod_restart}, 32'd1);
        chk("R2 divider slot", slot(0), 32'h0000_0246);
        @(negedge clk);
        chk("R8 pulse one cycle R10", {31'd0, mod_restart}, 32'd0);

        load(32'h0000_4043);
        chk("R8 mod_hold set", {31'd0, mod_hold}, 32'd1);
        load(32'h0000_0F00);
        chk("R8 no pulse when holding", {31'd0, mod_restart}, 32'd0);
        chk("R2 divider stored with hold", slot(0), 32'h0000_01E0);

        // same-cycle: sleep forcing with restart pulse
        load(32'h0000_0023);
        load(32'h0000_0808);
        chk("R8 pulse while asleep", {31'd0, mod_restart}, 32'd1);
        chk("R5 still asleep with pulse", {29'd0, pwr_down, cnt_hold, cp_tristate}, 32'd7);
        chk("R6 divider stored asleep", slot(0), 32'h0000_0101);
        load(32'h0000_0039);
        chk("R6 slot1 stored asleep", slot(1), 32'h0000_0007);
        chk("R6 slot2 kept asleep", slot(2), 32'h0020_0000);

        // back-to-back divider writes
        @(negedge clk);
        word_valid = 1'b1; word_data = 32'h0000_0010;
        @(negedge clk);
        word_data = 32'h0000_0020;
        @(negedge clk);
        word_valid = 1'b0; word_data = '0;
        chk("R8 back-to-back second cycle", {31'd0, mod_restart}, 32'd1);
        @(negedge clk);
        chk("R10 pulse drops", {31'd0, mod_restart}, 32'd0);

        // idle: no strobe, data toggling must change nothing
        word_data = 32'hFFFF_FFFB;
        repeat (3) @(negedge clk);
        chk("R10 idle outputs", {24'd0, obs}, {24'd0, 8'b0000_1111});
        chk("R10 idle slot3", slot(3), 32'h0000_0004);
        word_data = '0;

        // asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1;
        chk("R1 async reset outputs", {23'd0, mod_restart, obs}, 32'd0);
        chk("R1 async reset slot0", slot(0), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule